// File: doc/BRIEF.md
# Page write sequencer

The sequencer moves a run of bytes into a paged serial flash that owns an internal SRAM page buffer. A host starts it with a starting page number, a column within that page, a byte count and a verify flag. The run is cut into pieces that never cross a page edge. Before a piece that covers only part of a page, the flash is told to load that page into its buffer. This keeps the bytes the piece does not touch. The piece's own bytes are then sent with a combined erase-and-program command.

After every command that starts an internal flash operation, the sequencer polls the flash status until the ready flag is set. If verify is enabled, each programmed page is compared against the buffer, and a reported mismatch stops the run. The sequencer talks to a byte-level serial engine through a request/acknowledge pair, one byte at a time. The engine drops chip select after a byte that is flagged as the end of a transaction. Data bytes arrive on a valid/ready stream that is passed straight through to the engine.

Top module: `pgwr_seq`

## Requirements
- R1: The first piece is min(PAGE_SIZE - start column, length) bytes long. Every later piece starts at column 0 and is min(PAGE_SIZE, bytes left) long. The bytes of consecutive pieces are taken in stream order.
- R2: Before a piece shorter than PAGE_SIZE, the sequencer sends one transaction of four bytes: 0x53, address bits 23:16, address bits 15:8, then 0x00. The address is page << PAGE_SHIFT. A readiness wait follows this transaction.
- R3: A piece is programmed with 0x82, then address bits 23:16, 15:8 and 7:0 of (page << PAGE_SHIFT) + column, then the piece's data bytes. The end flag is set on the last data byte only. A readiness wait follows.
- R4: A readiness wait is a series of two-byte transactions, 0xD7 followed by 0x00. The byte received for the 0x00 is the status. The wait ends when status bit 7 is 1, and the remaining status bits do not count as ready.
- R5: With verify set, every programmed piece is followed by 0xD7-style waiting after a transaction 0x60, page address bits 23:16, 15:8, 0x00. If the ready status then has bit 6 set, the run ends with error code 1 and no further piece is written. Bit 6 is ignored after any other command.
- R6: If MAX_POLLS status bytes in one wait all show bit 7 at 0, the run ends with error code 2 and sends no further byte. MAX_POLLS - 1 busy replies followed by a ready reply do not cause this error.
- R7: din_ready is high only in a cycle where a data byte of a program transaction is acknowledged by the engine. It stays low while opcode, address and poll bytes are sent, and while the sequencer is idle.
- R8: A start with length 0 ends with error code 0 and sends no byte. A start received while busy is ignored.
- R9: After reset busy, done, din_ready and xfer_req are 0 and err_code is 0. done is a one-cycle pulse that presents the final err_code (0 on success), and busy is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (sampled while idle) |
| start_page | input | 24-PAGE_SHIFT | First page number |
| start_col | input | COL_W | Column within the first page |
| start_len | input | LEN_W | Number of bytes to write |
| verify_en | input | 1 | Compare each page after programming |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err_code | output | 2 | 0 ok, 1 compare mismatch, 2 ready timeout |
| din_valid | input | 1 | Stream byte valid |
| din_data | input | 8 | Stream byte |
| din_ready | output | 1 | Stream byte taken |
| xfer_req | output | 1 | Byte transfer request to serial engine |
| xfer_byte | output | 8 | Byte to shift out |
| xfer_end | output | 1 | Release chip select after this byte |
| xfer_ack | input | 1 | Engine finished the requested byte |
| xfer_rx | input | 8 | Byte shifted in during that transfer |

## Verification
The hardest condition to reach is a compare mismatch partway through a multi-page run. This path must stop cleanly after the failing compare's wait, with the remaining pieces never started. The bench's engine model counts compare commands and reports bit 6 on the ready reply of one chosen compare. Random runs pick that index, and a directed run targets the second of three pages. The model also sets bit 6 on every ready reply outside a compare, and gives exactly MAX_POLLS and MAX_POLLS - 1 busy replies to probe both sides of the timeout edge.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  localparam int ADDR_BITS = 24;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHUNK,
    S_HDR,
    S_DATA,
    S_POLL,
    S_FIN
  } state_t;

  typedef enum logic [1:0] {
    OP_PRE,
    OP_PROG,
    OP_CMP
  } op_t;

  localparam logic [7:0] CODE_PRELOAD = 8'h53;
  localparam logic [7:0] CODE_PROGRAM = 8'h82;
  localparam logic [7:0] CODE_COMPARE = 8'h60;
  localparam logic [7:0] CODE_STATUS  = 8'hD7;

  localparam logic [1:0] ERR_NONE     = 2'd0;
  localparam logic [1:0] ERR_MISMATCH = 2'd1;
  localparam logic [1:0] ERR_TIMEOUT  = 2'd2;
endpackage

// File: rtl/pgwr_chunk.sv
// Length of the piece that starts at the current column.
module pgwr_chunk #(
  parameter int PAGE_SIZE = 264,
  parameter int COL_W     = 9,
  parameter int LEN_W     = 16
) (
  input  logic [COL_W-1:0] col,
  input  logic [LEN_W-1:0] rem,
  output logic [LEN_W-1:0] chunk,
  output logic             partial
);
  localparam logic [LEN_W-1:0] PS = LEN_W'(PAGE_SIZE);

  logic [LEN_W-1:0] room;

  always_comb begin
    room    = PS - LEN_W'(col);
    chunk   = (rem < room) ? rem : room;
    partial = (chunk != PS);
  end
endmodule

// File: rtl/pgwr_hdr.sv
// Command header byte selector: opcode then three address bytes.
module pgwr_hdr
  import pgwr_pkg::*;
#(
  parameter int PAGE_SHIFT = 9,
  parameter int COL_W      = 9,
  parameter int PAGE_W     = ADDR_BITS - PAGE_SHIFT
) (
  input  op_t               op,
  input  logic [PAGE_W-1:0] page,
  input  logic [COL_W-1:0]  col,
  input  logic [1:0]        idx,
  output logic [7:0]        hdr_byte
);
  logic [ADDR_BITS-1:0] base;
  logic [ADDR_BITS-1:0] full;
  logic [ADDR_BITS-1:0] addr;
  logic [7:0]           opcode;

  always_comb begin
    base = {page, {PAGE_SHIFT{1'b0}}};
    full = base + ADDR_BITS'(col);
    if (op == OP_PROG) begin
      addr = full;
    end else begin
      addr = {base[ADDR_BITS-1:8], 8'h00};
    end
    case (op)
      OP_PRE:  opcode = CODE_PRELOAD;
      OP_CMP:  opcode = CODE_COMPARE;
      default: opcode = CODE_PROGRAM;
    endcase
    case (idx)
      2'd0:    hdr_byte = opcode;
      2'd1:    hdr_byte = addr[23:16];
      2'd2:    hdr_byte = addr[15:8];
      default: hdr_byte = addr[7:0];
    endcase
  end
endmodule

// File: rtl/pgwr_wait.sv
// Counts busy status replies within one readiness wait.
module pgwr_wait #(
  parameter int MAX_POLLS = 4096,
  parameter int CW        = $clog2(MAX_POLLS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bump,
  output logic expired
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en  = clr | bump;
    cnt_d   = clr ? '0 : cnt_q + 1'b1;
    expired = (cnt_q == CW'(MAX_POLLS - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/pgwr_seq.sv
// Page-splitting write sequencer for a buffered serial flash.
module pgwr_seq
  import pgwr_pkg::*;
#(
  parameter int PAGE_SIZE  = 264,
  parameter int PAGE_SHIFT = 9,
  parameter int LEN_W      = 16,
  parameter int MAX_POLLS  = 4096,
  parameter int COL_W      = $clog2(PAGE_SIZE),
  parameter int PAGE_W     = ADDR_BITS - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAGE_W-1:0] start_page,
  input  logic [COL_W-1:0]  start_col,
  input  logic [LEN_W-1:0]  start_len,
  input  logic              verify_en,
  output logic              busy,
  output logic              done,
  output logic [1:0]        err_code,
  input  logic              din_valid,
  input  logic [7:0]        din_data,
  output logic              din_ready,
  output logic              xfer_req,
  output logic [7:0]        xfer_byte,
  output logic              xfer_end,
  input  logic              xfer_ack,
  input  logic [7:0]        xfer_rx
);
  state_t            state_q, state_d;
  op_t               op_q, op_d;
  logic [1:0]        idx_q, idx_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic [COL_W-1:0]  col_q, col_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic              verify_q, verify_d;
  logic [1:0]        err_q, err_d;

  logic [LEN_W-1:0]  chunk;
  logic              partial;
  logic [7:0]        hdr_byte;
  logic              wait_clr;
  logic              wait_bump;
  logic              wait_expired;
  logic              advance;
  logic              last_data;
  logic              rx_unused;

  assign rx_unused = ^xfer_rx[5:0];

  pgwr_chunk #(
    .PAGE_SIZE(PAGE_SIZE),
    .COL_W    (COL_W),
    .LEN_W    (LEN_W)
  ) u_chunk (
    .col    (col_q),
    .rem    (rem_q),
    .chunk  (chunk),
    .partial(partial)
  );

  pgwr_hdr #(
    .PAGE_SHIFT(PAGE_SHIFT),
    .COL_W     (COL_W),
    .PAGE_W    (PAGE_W)
  ) u_hdr (
    .op      (op_q),
    .page    (page_q),
    .col     (col_q),
    .idx     (idx_q),
    .hdr_byte(hdr_byte)
  );

  pgwr_wait #(
    .MAX_POLLS(MAX_POLLS)
  ) u_wait (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (wait_clr),
    .bump   (wait_bump),
    .expired(wait_expired)
  );

  assign last_data = (cnt_q == chunk - 1'b1);

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    op_d      = op_q;
    idx_d     = idx_q;
    page_d    = page_q;
    col_d     = col_q;
    rem_d     = rem_q;
    cnt_d     = cnt_q;
    verify_d  = verify_q;
    err_d     = err_q;
    wait_clr  = 1'b0;
    wait_bump = 1'b0;
    advance   = 1'b0;

    case (state_q)
      S_IDLE: begin
        if (start) begin
          page_d   = start_page;
          col_d    = start_col;
          rem_d    = start_len;
          verify_d = verify_en;
          err_d    = ERR_NONE;
          state_d  = S_CHUNK;
        end
      end
      S_CHUNK: begin
        if (rem_q == '0) begin
          state_d = S_FIN;
        end else begin
          op_d    = partial ? OP_PRE : OP_PROG;
          idx_d   = 2'd0;
          state_d = S_HDR;
        end
      end
      S_HDR: begin
        if (xfer_ack) begin
          if (idx_q == 2'd3) begin
            idx_d = 2'd0;
            if (op_q == OP_PROG) begin
              cnt_d   = '0;
              state_d = S_DATA;
            end else begin
              wait_clr = 1'b1;
              state_d  = S_POLL;
            end
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      S_DATA: begin
        if (xfer_ack) begin
          cnt_d = cnt_q + 1'b1;
          if (last_data) begin
            wait_clr = 1'b1;
            idx_d    = 2'd0;
            state_d  = S_POLL;
          end
        end
      end
      S_POLL: begin
        if (xfer_ack) begin
          if (idx_q == 2'd0) begin
            idx_d = 2'd1;
          end else begin
            idx_d = 2'd0;
            if (xfer_rx[7]) begin
              case (op_q)
                OP_PRE: begin
                  op_d    = OP_PROG;
                  state_d = S_HDR;
                end
                OP_PROG: begin
                  if (verify_q) begin
                    op_d    = OP_CMP;
                    state_d = S_HDR;
                  end else begin
                    advance = 1'b1;
                  end
                end
                default: begin
                  if (xfer_rx[6]) begin
                    err_d   = ERR_MISMATCH;
                    state_d = S_FIN;
                  end else begin
                    advance = 1'b1;
                  end
                end
              endcase
            end else if (wait_expired) begin
              err_d   = ERR_TIMEOUT;
              state_d = S_FIN;
            end else begin
              wait_bump = 1'b1;
            end
          end
        end
      end
      S_FIN: begin
        state_d = S_IDLE;
      end
      default: begin
        state_d = S_IDLE;
      end
    endcase

    if (advance) begin
      rem_d   = rem_q - chunk;
      page_d  = page_q + 1'b1;
      col_d   = '0;
      state_d = S_CHUNK;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      op_q     <= OP_PROG;
      idx_q    <= 2'd0;
      page_q   <= '0;
      col_q    <= '0;
      rem_q    <= '0;
      cnt_q    <= '0;
      verify_q <= 1'b0;
      err_q    <= ERR_NONE;
    end else begin
      state_q  <= state_d;
      op_q     <= op_d;
      idx_q    <= idx_d;
      page_q   <= page_d;
      col_q    <= col_d;
      rem_q    <= rem_d;
      cnt_q    <= cnt_d;
      verify_q <= verify_d;
      err_q    <= err_d;
    end
  end

  // Outputs
  always_comb begin
    busy      = (state_q != S_IDLE);
    done      = (state_q == S_FIN);
    err_code  = err_q;
    din_ready = (state_q == S_DATA) && xfer_ack;
    xfer_req  = 1'b0;
    xfer_byte = 8'h00;
    xfer_end  = 1'b0;
    case (state_q)
      S_HDR: begin
        xfer_req  = 1'b1;
        xfer_byte = hdr_byte;
        xfer_end  = (idx_q == 2'd3) && (op_q != OP_PROG);
      end
      S_DATA: begin
        xfer_req  = din_valid;
        xfer_byte = din_data;
        xfer_end  = last_data;
      end
      S_POLL: begin
        xfer_req  = 1'b1;
        xfer_byte = (idx_q == 2'd0) ? CODE_STATUS : 8'h00;
        xfer_end  = (idx_q == 2'd1);
      end
      default: begin
        xfer_req = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/pgwr_seq_chk.sv
module pgwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [1:0] err_code,
  input logic       din_ready,
  input logic       xfer_req,
  input logic [7:0] xfer_byte,
  input logic       xfer_end,
  input logic       xfer_ack
);
  // R3: a pending byte request keeps its byte and end flag until acknowledged
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_byte) && $stable(xfer_end)));

  // R7: stream is only drained on an acknowledged transfer
  p_ready_on_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    din_ready |-> (xfer_ack && xfer_req && busy));

  // R7: idle sequencer is silent
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!xfer_req && !din_ready));

  // R9: done is a single pulse that ends the run
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R8: an accepted start makes the block busy
  p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R6: only the defined codes are reported
  p_code_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err_code != 2'd3));
endmodule

bind pgwr_seq pgwr_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .err_code (err_code),
  .din_ready(din_ready),
  .xfer_req (xfer_req),
  .xfer_byte(xfer_byte),
  .xfer_end (xfer_end),
  .xfer_ack (xfer_ack)
);

// File: tb/sim_pgwr_seq.sv
`timescale 1ns/1ps
module sim_pgwr_seq;
  localparam int PS    = 12;
  localparam int SH    = 8;
  localparam int MAXP  = 5;
  localparam int LW    = 16;
  localparam int CW    = 4;
  localparam int PW    = 24 - SH;
  localparam int DEPTH = 1024;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [PW-1:0] start_page = '0;
  logic [CW-1:0] start_col = '0;
  logic [LW-1:0] start_len = '0;
  logic          verify_en = 1'b0;
  logic          busy, done, din_ready, xfer_req, xfer_end;
  logic [1:0]    err_code;
  logic          din_valid = 1'b0;
  logic [7:0]    din_data = 8'h00;
  logic [7:0]    xfer_byte;
  logic          xfer_ack = 1'b0;
  logic [7:0]    xfer_rx = 8'h00;

  pgwr_seq #(
    .PAGE_SIZE (PS),
    .PAGE_SHIFT(SH),
    .LEN_W     (LW),
    .MAX_POLLS (MAXP)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_page(start_page),
    .start_col(start_col), .start_len(start_len), .verify_en(verify_en),
    .busy(busy), .done(done), .err_code(err_code),
    .din_valid(din_valid), .din_data(din_data), .din_ready(din_ready),
    .xfer_req(xfer_req), .xfer_byte(xfer_byte), .xfer_end(xfer_end),
    .xfer_ack(xfer_ack), .xfer_rx(xfer_rx)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  // engine configuration (written by main only)
  int k_cfg = 0;
  int mism_cfg = -1;

  // engine log
  logic [7:0] log_b [DEPTH];
  logic       log_e [DEPTH];
  int         log_n = 0;

  // expected transcript
  logic [7:0] exp_b [DEPTH];
  logic       exp_e [DEPTH];
  logic [7:0] exp_o [DEPTH];
  int         exp_n;
  int         exp_err;
  int         exp_data;

  logic start_seen = 1'b0;
  logic fire = 1'b0;
  int   nacc = 0;

  always @(posedge clk) begin
    start_seen <= start && !busy;
    fire       <= din_valid && din_ready;
  end

  function automatic logic [7:0] pat(input int g);
    return 8'((g * 37 + 90) & 255);
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles >= 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired actual %0d expected below %0d", cycles, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, fails);
      $finish;
    end
  end

  // serial byte engine and flash status model
  initial begin
    int dly = 0;
    int pos = 0;
    int busy_left = 0;
    int cmp_idx = 0;
    logic [7:0] cur_op = 8'h00;
    logic [7:0] last_op = 8'h00;
    logic [7:0] rx;
    forever begin
      @(negedge clk);
      if (start_seen) begin
        pos = 0; busy_left = k_cfg; cmp_idx = 0; log_n = 0;
        cur_op = 8'h00; last_op = 8'h00;
      end
      if (xfer_ack) begin
        xfer_ack = 1'b0;
        dly = int'($urandom % 3);
      end else if (xfer_req) begin
        if (dly > 0) begin
          dly = dly - 1;
        end else begin
          rx = 8'($urandom);
          if (pos == 0) cur_op = xfer_byte;
          if (pos == 1 && cur_op == 8'hD7) begin
            if (busy_left > 0) begin
              busy_left = busy_left - 1;
              rx = rx & 8'h7F;
            end else begin
              rx = 8'h80 | (rx & 8'h3F);
              if (last_op == 8'h60) begin
                if (cmp_idx == mism_cfg) rx = rx | 8'h40;
                cmp_idx = cmp_idx + 1;
              end else begin
                rx = rx | 8'h40;
              end
            end
          end
          if (log_n < DEPTH) begin
            log_b[log_n] = xfer_byte;
            log_e[log_n] = xfer_end;
          end
          log_n = log_n + 1;
          if (xfer_end) begin
            if (cur_op != 8'hD7) begin
              last_op = cur_op;
              busy_left = k_cfg;
            end
            pos = 0;
          end else begin
            pos = pos + 1;
          end
          xfer_rx = rx;
          xfer_ack = 1'b1;
        end
      end
    end
  end

  // data stream source
  initial begin
    int g = 0;
    forever begin
      @(negedge clk);
      if (start_seen) begin
        g = 0; nacc = 0; din_valid = 1'b0;
      end else begin
        if (fire) begin
          g = g + 1;
          nacc = nacc + 1;
        end
        if (!din_valid || fire) begin
          din_valid = (($urandom % 4) != 0);
          din_data = pat(g);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic push(input logic [7:0] b, input bit e, input logic [7:0] o);
    if (exp_n < DEPTH) begin
      exp_b[exp_n] = b; exp_e[exp_n] = e; exp_o[exp_n] = o;
    end
    exp_n = exp_n + 1;
  endtask

  task automatic exp_wait(input int k, output bit ok);
    int n;
    n = (k >= MAXP) ? MAXP : k + 1;
    for (int i = 0; i < n; i++) begin
      push(8'hD7, 1'b0, 8'hD7);
      push(8'h00, 1'b1, 8'hD7);
    end
    ok = (k < MAXP);
    if (!ok) exp_err = 2;
  endtask

  task automatic build(input int pg, input int col, input int len, input int vf,
                       input int k, input int mi);
    int rem, c, p, ch, g, ci;
    logic [23:0] pa, a;
    bit ok;
    exp_n = 0; exp_err = 0; exp_data = 0;
    rem = len; c = col; p = pg; g = 0; ci = 0;
    while (rem > 0) begin
      ch = (PS - c < rem) ? PS - c : rem;
      pa = 24'(p) << SH;
      if (ch != PS) begin
        push(8'h53, 1'b0, 8'h53); push(pa[23:16], 1'b0, 8'h53);
        push(pa[15:8], 1'b0, 8'h53); push(8'h00, 1'b1, 8'h53);
        exp_wait(k, ok);
        if (!ok) return;
      end
      a = pa + 24'(c);
      push(8'h82, 1'b0, 8'h82); push(a[23:16], 1'b0, 8'h82);
      push(a[15:8], 1'b0, 8'h82); push(a[7:0], 1'b0, 8'h82);
      for (int i = 0; i < ch; i++) begin
        push(pat(g), (i == ch - 1), 8'h82);
        g = g + 1;
        exp_data = exp_data + 1;
      end
      exp_wait(k, ok);
      if (!ok) return;
      if (vf != 0) begin
        push(8'h60, 1'b0, 8'h60); push(pa[23:16], 1'b0, 8'h60);
        push(pa[15:8], 1'b0, 8'h60); push(8'h00, 1'b1, 8'h60);
        exp_wait(k, ok);
        if (!ok) return;
        if (ci == mi) begin
          exp_err = 1;
          return;
        end
        ci = ci + 1;
      end
      rem = rem - ch; p = p + 1; c = 0;
    end
  endtask

  function automatic string req_of(input logic [7:0] o);
    case (o)
      8'h53:   return "R2 preload command";
      8'h82:   return "R3 program command";
      8'h60:   return "R5 compare command";
      default: return "R4 status poll";
    endcase
  endfunction

  task automatic run_test(input int pg, input int col, input int len, input int vf,
                          input int k, input int mi, input bit rs, input string nm);
    int cyc, first, got_err, n;
    build(pg, col, len, vf, k, mi);
    k_cfg = k; mism_cfg = mi;
    @(negedge clk);
    start = 1'b1; start_page = PW'(pg); start_col = CW'(col);
    start_len = LW'(len); verify_en = (vf != 0);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 20000) begin
      if (rs && cyc == 6) begin
        start = 1'b1; start_len = LW'(3); start_col = '0; verify_en = 1'b0;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc = cyc + 1;
    end
    start = 1'b0;
    got_err = int'(err_code);
    chk(done == 1'b1, {"R9 done reached ", nm}, int'(done), 1);
    @(negedge clk);
    chk(!done && !busy, {"R9 single done pulse ", nm}, int'({done, busy}), 0);
    chk(log_n == exp_n, {"R1 transcript length ", nm}, log_n, exp_n);
    n = (log_n < exp_n) ? log_n : exp_n;
    if (n > DEPTH) n = DEPTH;
    first = -1;
    for (int i = 0; i < n; i++) begin
      if (first < 0 && (log_b[i] !== exp_b[i] || log_e[i] !== exp_e[i])) first = i;
    end
    if (first >= 0) begin
      chk(1'b0, {req_of(exp_o[first]), " byte ", nm},
          int'({log_e[first], log_b[first]}), int'({exp_e[first], exp_b[first]}));
    end else begin
      chk(1'b1, {"R3 transcript ", nm}, 0, 0);
    end
    if (exp_err == 1)
      chk(got_err == exp_err, {"R5 mismatch code ", nm}, got_err, exp_err);
    else if (exp_err == 2)
      chk(got_err == exp_err, {"R6 timeout code ", nm}, got_err, exp_err);
    else
      chk(got_err == exp_err, {"R9 success code ", nm}, got_err, exp_err);
    chk(nacc == exp_data, {"R7 stream bytes taken ", nm}, nacc, exp_data);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!busy && !done && !din_ready && !xfer_req && err_code == 2'd0,
        "R9 reset outputs", int'({busy, done, din_ready, xfer_req, err_code}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !xfer_req, "R9 idle after reset", int'({busy, xfer_req}), 0);

    run_test(3, 0, PS, 0, 0, -1, 1'b0, "aligned full page");          // R1 R3
    run_test(7, 5, 20, 1, 1, -1, 1'b0, "partial spanning verify");    // R1 R2 R4 R5
    run_test(9, 4, 0, 1, 0, -1, 1'b0, "zero length");                 // R8
    run_test(2, 0, 30, 1, 0, 1, 1'b0, "mismatch on second page");     // R5
    run_test(5, 3, 4, 0, MAXP, -1, 1'b0, "timeout");                  // R6
    run_test(5, 0, 14, 0, MAXP - 1, -1, 1'b0, "just under timeout");  // R6
    run_test(11, 10, 9, 0, 0, -1, 1'b0, "restart ignored");            // R8 baseline
    run_test(11, 10, 9, 0, 0, -1, 1'b1, "restart while busy");         // R8
    run_test(4, 11, 1, 1, 2, -1, 1'b0, "last column single byte");    // R1 R2

    for (int t = 0; t < 24; t++) begin
      int pg, col, len, vf, k, mi;
      pg  = int'($urandom % 60000);
      col = int'($urandom % PS);
      len = int'($urandom % 40);
      vf  = int'($urandom % 2);
      k   = int'($urandom % 3);
      mi  = (($urandom % 4) == 0) ? int'($urandom % 3) : -1;
      run_test(pg, col, len, vf, k, mi, 1'b0, "random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, fails);
    $finish;
  end
endmodule